// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block is the bus-master side of a cache refill path. A requester hands it one operand address and a no-cache attribute over a valid/ready request channel. The block turns that request into a single indivisible read of a 16-byte line on a synchronous external bus, made of four 32-bit long words. The first word fetched is the one that holds the requested address. The remaining three follow in ascending long-word order and wrap around inside the line.

If the target accepts bursting, the four words arrive as one burst after a single transfer start. If the target signals burst inhibit with its first acknowledge, the block instead issues three more single long-word cycles. Those cycles remain part of the same line transaction. Acknowledges can be masked for a programmable number of clocks at the start of every data beat, so a slow or high-frequency target can ignore early termination glitches.

Once all four words are captured, the assembled line is offered on a valid/ready response channel in fetch order, together with the cache-inhibit flag the target returned with its first acknowledge. The response is held stable until the requester takes it. No new request is accepted until then, which provides the back-pressure on both channels.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and bus_ts, bus_tip and rsp_valid are 0.
- R2: The clock after a request is accepted, bus_ts is 1 for exactly one clock. In that clock bus_tip is 1, bus_rw is 1 and bus_size is the line code 2'b11.
- R3: The k-th beat (k = 0..3) addresses long word (req_addr[3:2] + k) mod 4 of the line. Bits 31:4 and bits 1:0 of bus_addr are taken unchanged from req_addr.
- R4: Until a beat's acknowledge is accepted, bus_addr and bus_size stay stable and bus_ts stays 0. Any number of wait clocks is allowed.
- R5: Each beat's data phase starts the clock after bus_ts, or the clock after the previous accepted acknowledge. An acknowledge is accepted only in a data-phase clock that has at least cfg_ack_skip earlier data-phase clocks in the same beat. Data and attributes presented with an ignored acknowledge are discarded.
- R6: If bus_bi is 1 at the first accepted acknowledge, each remaining word gets its own cycle. That cycle has a one-clock bus_ts, the long-word size code 2'b00, the next wrapped address, and bus_addr[1:0] unchanged.
- R7: bus_bi has no effect at any acknowledge other than the first accepted one.
- R8: rsp_nocache equals bus_ci as sampled at the first accepted acknowledge. bus_ci at later acknowledges has no effect, and bus_ci never changes how the line completes.
- R9: From acceptance until the response is taken, req_ready is 0, and no transfer start for another line appears.
- R10: rsp_valid stays 1, with rsp_line and rsp_nocache stable, until rsp_ready is 1. Word k of rsp_line (bits 32k+31:32k) is the data of the k-th accepted beat.
- R11: bus_tip is 1 throughout the line transaction. It is 0 from the clock rsp_valid rises until the next request is accepted.
- R12: During the line transaction, bus_nocache_out carries the request's no-cache attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ack_skip | input | 3 | Data-phase clocks to ignore acknowledge per beat |
| req_valid | input | 1 | Fill request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 32 | Operand address of the miss |
| req_nocache | input | 1 | Request no-cache attribute |
| rsp_valid | output | 1 | Completed line available |
| rsp_ready | input | 1 | Requester takes the line |
| rsp_line | output | 128 | Line in fetch order, word k at bits 32k+31:32k |
| rsp_nocache | output | 1 | Cache-inhibit flag from first acknowledge |
| bus_addr | output | 32 | Bus address |
| bus_ts | output | 1 | Transfer start |
| bus_tip | output | 1 | Transfer in progress |
| bus_rw | output | 1 | Read/write, 1 = read |
| bus_size | output | 2 | Size code: 2'b11 line, 2'b00 long word |
| bus_nocache_out | output | 1 | Request attribute driven on the bus |
| bus_data_in | input | 32 | Read data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_bi | input | 1 | Burst inhibit from target |
| bus_ci | input | 1 | Cache inhibit from target |

## Verification
Lines are requested at every word offset within a line, including a non-aligned byte offset in the last word. This separates correct wrapping from a linear or half-line fetch order. Burst and burst-inhibited lines are both run, with mixed per-beat wait counts and several acknowledge-ignore settings. During ignored clocks the bench drives wrong data and inverted burst-inhibit and cache-inhibit values. Any early sampling then shows up as a corrupted word, a spurious transfer start or a wrong flag. Later beats also carry inverted burst-inhibit and cache-inhibit, so re-sampling after the first acknowledge is exposed. The response is held back for varying numbers of clocks to test that it stays stable.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } lfc_state_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_LINE = 2'b11;
endpackage

// File: rtl/lfc_seq.sv
module lfc_seq
  import lfc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int SKW   = 3,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            rsp_ready,
  input  logic            bus_ack,
  input  logic            bus_bi,
  input  logic [SKW-1:0]  cfg_skip,
  output logic            req_ready,
  output logic            accept,
  output logic            ts,
  output logic            tip,
  output logic            line_size,
  output logic [IDXW-1:0] beat,
  output logic            cap,
  output logic            cap_first,
  output logic            rsp_valid
);
  localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);
  localparam logic [SKW-1:0]  CMAX = {SKW{1'b1}};

  lfc_state_e      state_q;
  logic [IDXW-1:0] beat_q;
  logic [SKW-1:0]  cnt_q;
  logic            burst_q;
  logic            ack_ok;

  // acknowledge counts only once the per-beat ignore window has passed
  assign ack_ok = (state_q == ST_DATA) && bus_ack && (cnt_q >= cfg_skip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      cnt_q   <= '0;
      burst_q <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_ADDR;
            beat_q  <= '0;
            burst_q <= 1'b1;
          end
        end
        ST_ADDR: begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: begin
          if (ack_ok) begin
            cnt_q <= '0;
            if (beat_q == LAST) begin
              state_q <= ST_RESP;
            end else begin
              beat_q <= beat_q + 1'b1;
              if (beat_q == '0) begin
                burst_q <= !bus_bi;
                state_q <= bus_bi ? ST_ADDR : ST_DATA;
              end else begin
                state_q <= burst_q ? ST_DATA : ST_ADDR;
              end
            end
          end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign ts        = (state_q == ST_ADDR);
  assign tip       = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign line_size = (beat_q == '0);
  assign beat      = beat_q;
  assign cap       = ack_ok;
  assign cap_first = ack_ok && (beat_q == '0);
  assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/lfc_addr_gen.sv
module lfc_addr_gen #(
  parameter int AW    = 32,
  parameter int WORDS = 4,
  localparam int IDXW = $clog2(WORDS),
  localparam int HI   = IDXW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_nocache,
  input  logic [IDXW-1:0] beat,
  output logic [AW-1:0]   bus_addr,
  output logic            nocache
);
  logic [AW-1:0]   addr_q;
  logic            nc_q;
  logic [IDXW-1:0] word_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      nc_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      nc_q   <= req_nocache;
    end
  end

  // critical word first, wrapping modulo the line
  assign word_idx = addr_q[HI-1:2] + beat;
  assign bus_addr = {addr_q[AW-1:HI], word_idx, addr_q[1:0]};
  assign nocache  = nc_q;
endmodule

// File: rtl/lfc_line_buf.sv
module lfc_line_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             cap_first,
  input  logic [IDXW-1:0]  beat,
  input  logic [DW-1:0]    data_in,
  input  logic             ci_in,
  output logic [WORDS*DW-1:0] line,
  output logic             ci_flag
);
  for (genvar s = 0; s < WORDS; s++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (cap && beat == IDXW'(s)) word_q <= data_in;
    end
    assign line[s*DW +: DW] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ci_flag <= 1'b0;
    else if (cap_first) ci_flag <= ci_in;
  end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int SKW   = 3,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SKW-1:0]      cfg_ack_skip,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_nocache,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORDS*DW-1:0] rsp_line,
  output logic                rsp_nocache,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_ts,
  output logic                bus_tip,
  output logic                bus_rw,
  output logic [1:0]          bus_size,
  output logic                bus_nocache_out,
  input  logic [DW-1:0]       bus_data_in,
  input  logic                bus_ack,
  input  logic                bus_bi,
  input  logic                bus_ci
);
  logic            accept;
  logic            line_size;
  logic [IDXW-1:0] beat;
  logic            cap;
  logic            cap_first;

  lfc_seq #(.WORDS(WORDS), .SKW(SKW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .bus_ack   (bus_ack),
    .bus_bi    (bus_bi),
    .cfg_skip  (cfg_ack_skip),
    .req_ready (req_ready),
    .accept    (accept),
    .ts        (bus_ts),
    .tip       (bus_tip),
    .line_size (line_size),
    .beat      (beat),
    .cap       (cap),
    .cap_first (cap_first),
    .rsp_valid (rsp_valid)
  );

  lfc_addr_gen #(.AW(AW), .WORDS(WORDS)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_nocache (req_nocache),
    .beat        (beat),
    .bus_addr    (bus_addr),
    .nocache     (bus_nocache_out)
  );

  lfc_line_buf #(.DW(DW), .WORDS(WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap),
    .cap_first (cap_first),
    .beat      (beat),
    .data_in   (bus_data_in),
    .ci_in     (bus_ci),
    .line      (rsp_line),
    .ci_flag   (rsp_nocache)
  );

  assign bus_rw   = 1'b1;
  assign bus_size = line_size ? SZ_LINE : SZ_LONG;
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int AW = 32,
  parameter int LW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [LW-1:0] rsp_line,
  input logic          rsp_nocache,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ts,
  input logic          bus_tip,
  input logic [1:0]    bus_size,
  input logic          bus_ack
);
  p_ts_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);
  p_ts_inside_tip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |-> bus_tip);
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tip && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_size)));
  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tip && $past(bus_tip)) |-> $stable(bus_addr[1:0]));
  p_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tip |-> !req_ready);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_line) && $stable(rsp_nocache)));
  p_tip_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_tip);
endmodule

bind line_fill_ctrl lfc_checker #(.AW(AW), .LW(WORDS*DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_line    (rsp_line),
  .rsp_nocache (rsp_nocache),
  .bus_addr    (bus_addr),
  .bus_ts      (bus_ts),
  .bus_tip     (bus_tip),
  .bus_size    (bus_size),
  .bus_ack     (bus_ack)
);

// File: tb/line_fill_ctrl_test.sv
`timescale 1ns/1ps
module line_fill_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cfg_ack_skip = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_nocache = 1'b0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [127:0] rsp_line;
  logic         rsp_nocache;
  logic [31:0]  bus_addr;
  logic         bus_ts, bus_tip, bus_rw, bus_nocache_out;
  logic [1:0]   bus_size;
  logic [31:0]  bus_data_in = '0;
  logic         bus_ack = 1'b0, bus_bi = 1'b0, bus_ci = 1'b0;

  typedef struct { logic [127:0] line; logic ci; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, n_done = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  line_fill_ctrl uut (.*);

  function automatic logic [31:0] memw(logic [31:0] a);
    return (a >> 2) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] beat_addr(logic [31:0] a, int k);
    logic [1:0] w;
    w = a[3:2] + 2'(k);
    return {a[31:4], w, a[1:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // driver: pushes the expected line, then plays the target side of the bus
  task automatic run_line(logic [31:0] a, logic ci, logic bi, int skip,
                          int w0, int w1, int w2, int w3);
    int   w[4];
    exp_t e;
    logic burst;
    w = '{w0, w1, w2, w3};
    for (int k = 0; k < 4; k++) e.line[k*32 +: 32] = memw(beat_addr(a, k));
    e.ci = ci;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_ack_skip = 3'(skip);
    req_addr = a; req_nocache = ci; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_nocache = ~ci;
    burst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (k == 0 || !burst) begin
        chk(bus_ts && bus_tip && bus_rw, "R2 start strobe", {bus_ts, bus_tip, bus_rw}, 3'b111);
        if (k == 0) chk(bus_size == 2'b11, "R2 line size", bus_size, 2'b11);
        else        chk(bus_size == 2'b00, "R6 long size", bus_size, 2'b00);
        chk(bus_addr == beat_addr(a, k), k == 0 ? "R3 first addr" : "R6 fallback addr",
            bus_addr, beat_addr(a, k));
        chk(bus_nocache_out == ci, "R12 attribute", bus_nocache_out, ci);
        chk(!req_ready, "R9 atomic", req_ready, 0);
        @(negedge clk);
      end
      for (int c = 0; ; c++) begin
        bit take;
        take = (c >= w[k]) && (c >= skip);
        chk(!bus_ts && bus_addr == beat_addr(a, k), "R4/R3 beat hold",
            {bus_ts, bus_addr}, {1'b0, beat_addr(a, k)});
        chk(bus_tip, "R11 tip held", bus_tip, 1);
        bus_ack = (c >= w[k]);
        bus_data_in = take ? memw(beat_addr(a, k)) : ~memw(beat_addr(a, k));
        bus_bi = (k == 0 && take) ? bi : ~bi;   // R5 R7: wrong values when not sampled
        bus_ci = (k == 0 && take) ? ci : ~ci;   // R8
        @(negedge clk);
        if (take) break;
      end
      bus_ack = 1'b0;
      if (k == 0) burst = !bi;
    end
    chk(!bus_tip && !bus_ts, "R11 tip off", {bus_tip, bus_ts}, 0);
    chk(!req_ready, "R9 busy until taken", req_ready, 0);
  endtask

  // monitor: pops the scoreboard as lines are delivered
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && exp_q.size() > 0) begin
        logic [127:0] snap;
        logic         sci;
        exp_t         e;
        snap = rsp_line; sci = rsp_nocache;
        for (int i = 0; i < n_done % 3; i++) begin
          @(negedge clk);
          chk(rsp_valid && rsp_line == snap && rsp_nocache == sci, "R10 hold",
              rsp_line, snap);
        end
        e = exp_q.pop_front();
        chk(rsp_line == e.line, "R10/R5 line data", rsp_line, e.line);
        chk(rsp_nocache == e.ci, "R8 cache-inhibit", rsp_nocache, e.ci);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        n_done++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d lines", n_done, 5);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_ts && !bus_tip && !rsp_valid, "R1 reset",
        {req_ready, bus_ts, bus_tip, rsp_valid}, 4'b1000);
    run_line(32'h1000_000E, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    run_line(32'h2000_0004, 1'b1, 1'b0, 0, 2, 0, 1, 3);
    run_line(32'h3000_0009, 1'b0, 1'b1, 0, 0, 1, 0, 2);
    run_line(32'h4000_000F, 1'b1, 1'b1, 2, 0, 3, 1, 0);
    run_line(32'h5000_0000, 1'b1, 1'b0, 3, 1, 0, 0, 5);
    while (n_done < 5) @(negedge clk);
    @(negedge clk);
    chk(req_ready && !bus_tip && !rsp_valid, "R11 idle after take",
        {req_ready, bus_tip, rsp_valid}, 3'b100);
    finish_run();
  end
endmodule